// File: doc/BRIEF.md
# Three-Tone LED Keying Modulator

The block turns a short serial frame into one square-wave level for the enable pin of an LED driver. A low level turns the driver's gate off and a high level turns it on, so every symbol becomes a burst of light pulses at one of three tone frequencies. A start request first sends a preamble tone for a fixed number of periods so that a receiver can lock onto the frame. After that, payload bits are taken one at a time over a valid/ready handshake. Each bit is sent as the zero tone or the one tone for a fixed number of system clocks, rounded up to the next whole period.

Every period opens with its low phase. That low phase is half the period, but it is capped at a maximum low time, so the driver's bootstrap supply cannot run down. The rest of the period is high. Outside a frame the output rests high, which keeps the LED lit. The system clock rate, the three tone frequencies, the preamble length, the symbol length and the low-time cap are all parameters. Each tone frequency must be 1 kHz or below.

Top module: `mfk_modulator`

## Requirements
- R1: A payload bit of value 0 selects the zero tone. Its period is CLK_HZ/F_ZERO clocks, and it starts with low_clks clocks of `dim_o`=0 followed by high for the rest of the period.
- R2: A payload bit of value 1 selects the one tone. Its period is CLK_HZ/F_ONE clocks and it has the same low-first shape.
- R3: After a start request, the preamble tone (period CLK_HZ/F_PRE clocks) is sent for exactly PRE_PERIODS whole periods.
- R4: For every tone, low_clks = min(period/2, CLK_HZ*MAX_LOW_US/1e6), so no low phase exceeds MAX_LOW_US microseconds.
- R5: `bit_ready_o` is 1 only in the last clock of the final preamble period and in the last clock of a symbol's final period. A bit is taken when `bit_valid_i` and `bit_ready_o` are both 1, and its tone begins in the next clock.
- R6: After reset and whenever no frame is running, `dim_o`=1, `busy_o`=0 and `bit_ready_o`=0.
- R7: `start_i` is ignored while `busy_o`=1.
- R8: When `start_i`=1 while idle, `busy_o`=1 and `dim_o`=0 appear in the next clock, and that clock is the first clock of the preamble.
- R9: A symbol ends at the end of the first period whose last clock brings the symbol's clock count to at least SYM_CLKS. Tones change only at period ends.
- R10: If `bit_valid_i`=0 when `bit_ready_o`=1, the frame ends. In the next clock `busy_o`=0 and `dim_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Frame start request |
| bit_valid_i | input | 1 | Payload bit offered |
| bit_i | input | 1 | Payload bit value |
| bit_ready_o | output | 1 | Payload bit taken in this clock if valid |
| dim_o | output | 1 | Driver enable level, 1 = LED on |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong period or low-phase counter shows on `dim_o` in the first tone period where it goes wrong: the rising or falling edge lands one or more clocks off. A fault in the preamble count, symbol count or sequencer state shows at the next symbol boundary. There `bit_ready_o`, the tone that follows, or the return of `busy_o` to 0 happens in the wrong clock. The bench compares all three outputs against a behavioural model on every clock, so each such fault is reported in the clock where it first reaches a port.

// File: rtl/mfk_pkg.sv
package mfk_pkg;

    typedef enum logic [1:0] {
        TONE_PRE  = 2'd0,
        TONE_ZERO = 2'd1,
        TONE_ONE  = 2'd2
    } tone_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } state_e;

    localparam int unsigned NUM_TONES = 3;

    function automatic int unsigned period_clks(input int unsigned clk_hz,
                                                input int unsigned freq_hz);
        return clk_hz / freq_hz;
    endfunction

    function automatic int unsigned cap_clks(input int unsigned clk_hz,
                                             input int unsigned max_low_us);
        longint unsigned prod;
        prod = longint'(clk_hz) * longint'(max_low_us);
        return int'(prod / 64'd1000000);
    endfunction

    function automatic int unsigned low_clks(input int unsigned per,
                                             input int unsigned cap);
        return ((per / 2) < cap) ? (per / 2) : cap;
    endfunction

    function automatic int unsigned min3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/mfk_tone_gen.sv
module mfk_tone_gen #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned F_PRE      = 500,
    parameter int unsigned F_ZERO     = 750,
    parameter int unsigned F_ONE      = 1000,
    parameter int unsigned MAX_LOW_US = 200,
    parameter int unsigned CNT_W      = 17
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            run_i,
    input  mfk_pkg::tone_e  tone_i,
    output logic            pin_o,
    output logic            period_end_o
);
    localparam int unsigned CAP = mfk_pkg::cap_clks(CLK_HZ, MAX_LOW_US);

    logic [CNT_W-1:0] last_tbl [mfk_pkg::NUM_TONES];
    logic [CNT_W-1:0] low_tbl  [mfk_pkg::NUM_TONES];

    for (genvar g = 0; g < int'(mfk_pkg::NUM_TONES); g++) begin : g_tone
        localparam int unsigned FREQ = (g == 0) ? F_PRE : (g == 1) ? F_ZERO : F_ONE;
        localparam int unsigned PER  = mfk_pkg::period_clks(CLK_HZ, FREQ);
        localparam int unsigned LOW  = mfk_pkg::low_clks(PER, CAP);
        assign last_tbl[g] = CNT_W'(PER - 1);
        assign low_tbl[g]  = CNT_W'(LOW);
    end

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_last;
    logic [CNT_W-1:0] cur_low;

    always_comb begin
        cur_last = last_tbl[0];
        cur_low  = low_tbl[0];
        case (tone_i)
            mfk_pkg::TONE_ZERO: begin cur_last = last_tbl[1]; cur_low = low_tbl[1]; end
            mfk_pkg::TONE_ONE:  begin cur_last = last_tbl[2]; cur_low = low_tbl[2]; end
            default:            begin cur_last = last_tbl[0]; cur_low = low_tbl[0]; end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == cur_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pin_o        = !run_i || (cnt_q >= cur_low);
    assign period_end_o = run_i && (cnt_q == cur_last);

endmodule

// File: rtl/mfk_seq.sv
module mfk_seq #(
    parameter int unsigned PRE_PERIODS = 8,
    parameter int unsigned SYM_CLKS    = 2_000_000
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            start_i,
    input  logic            bit_valid_i,
    input  logic            bit_i,
    input  logic            period_end_i,
    output logic            run_o,
    output mfk_pkg::tone_e  tone_o,
    output logic            ready_o,
    output logic            busy_o
);
    localparam int unsigned PRE_W = $clog2(PRE_PERIODS + 1);
    localparam int unsigned SYM_W = $clog2(SYM_CLKS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_PERIODS - 1);
    localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(SYM_CLKS - 1);

    mfk_pkg::state_e  state_q;
    mfk_pkg::tone_e   tone_q;
    logic [PRE_W-1:0] pre_q;
    logic [SYM_W-1:0] sym_q;
    logic             boundary;

    always_comb begin
        boundary = 1'b0;
        if (period_end_i) begin
            if (state_q == mfk_pkg::ST_PRE)  boundary = (pre_q == PRE_LAST);
            if (state_q == mfk_pkg::ST_DATA) boundary = (sym_q == SYM_LAST);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= mfk_pkg::ST_IDLE;
            tone_q  <= mfk_pkg::TONE_PRE;
            pre_q   <= '0;
            sym_q   <= '0;
        end else if (state_q == mfk_pkg::ST_IDLE) begin
            pre_q <= '0;
            sym_q <= '0;
            if (start_i) begin
                state_q <= mfk_pkg::ST_PRE;
                tone_q  <= mfk_pkg::TONE_PRE;
            end
        end else if (boundary) begin
            sym_q <= '0;
            pre_q <= '0;
            if (bit_valid_i) begin
                state_q <= mfk_pkg::ST_DATA;
                tone_q  <= bit_i ? mfk_pkg::TONE_ONE : mfk_pkg::TONE_ZERO;
            end else begin
                state_q <= mfk_pkg::ST_IDLE;
                tone_q  <= mfk_pkg::TONE_PRE;
            end
        end else begin
            if (state_q == mfk_pkg::ST_PRE && period_end_i) pre_q <= pre_q + 1'b1;
            if (state_q == mfk_pkg::ST_DATA && sym_q != SYM_LAST) sym_q <= sym_q + 1'b1;
        end
    end

    assign run_o   = (state_q != mfk_pkg::ST_IDLE);
    assign busy_o  = run_o;
    assign tone_o  = tone_q;
    assign ready_o = boundary;

endmodule

// File: rtl/mfk_modulator.sv
module mfk_modulator #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned F_PRE       = 500,
    parameter int unsigned F_ZERO      = 750,
    parameter int unsigned F_ONE       = 1000,
    parameter int unsigned MAX_LOW_US  = 200,
    parameter int unsigned PRE_PERIODS = 8,
    parameter int unsigned SYM_CLKS    = 2_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic bit_ready_o,
    output logic dim_o,
    output logic busy_o
);
    localparam int unsigned MAX_PER =
        mfk_pkg::period_clks(CLK_HZ, mfk_pkg::min3(F_PRE, F_ZERO, F_ONE));
    localparam int unsigned CNT_W = $clog2(MAX_PER + 1);

    logic           run;
    logic           period_end;
    mfk_pkg::tone_e tone;

    mfk_seq #(
        .PRE_PERIODS (PRE_PERIODS),
        .SYM_CLKS    (SYM_CLKS)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .start_i      (start_i),
        .bit_valid_i  (bit_valid_i),
        .bit_i        (bit_i),
        .period_end_i (period_end),
        .run_o        (run),
        .tone_o       (tone),
        .ready_o      (bit_ready_o),
        .busy_o       (busy_o)
    );

    mfk_tone_gen #(
        .CLK_HZ     (CLK_HZ),
        .F_PRE      (F_PRE),
        .F_ZERO     (F_ZERO),
        .F_ONE      (F_ONE),
        .MAX_LOW_US (MAX_LOW_US),
        .CNT_W      (CNT_W)
    ) u_tone (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .run_i        (run),
        .tone_i       (tone),
        .pin_o        (dim_o),
        .period_end_o (period_end)
    );

endmodule

// File: rtl/mfk_checker.sv
module mfk_checker #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned MAX_LOW_US = 200
) (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic bit_valid_i,
    input logic bit_ready_o,
    input logic dim_o,
    input logic busy_o
);
    localparam int unsigned CAP = mfk_pkg::cap_clks(CLK_HZ, MAX_LOW_US);

    int unsigned low_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || dim_o) low_run_q <= 0;
        else                low_run_q <= low_run_q + 1;
    end

    AST_LOW_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        !dim_o |-> (low_run_q < CAP)); // R4

    AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (dim_o && !bit_ready_o)); // R6

    AST_START_ENTERS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && start_i) |=> (busy_o && !dim_o)); // R8

    AST_NO_VALID_ENDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_ready_o && !bit_valid_i) |=> (!busy_o && dim_o)); // R10

    AST_TAKEN_STARTS: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_ready_o && bit_valid_i) |=> (busy_o && !dim_o)); // R5

endmodule

bind mfk_modulator mfk_checker #(
    .CLK_HZ     (CLK_HZ),
    .MAX_LOW_US (MAX_LOW_US)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .bit_valid_i (bit_valid_i),
    .bit_ready_o (bit_ready_o),
    .dim_o       (dim_o),
    .busy_o      (busy_o)
);

// File: tb/tb_mfk_modulator.sv
module tb_mfk_modulator;
    localparam int CLK_HZ = 60000;
    localparam int F_PRE = 500, F_ZERO = 750, F_ONE = 1000;
    localparam int MAX_LOW_US = 200;
    localparam int PRE_PERIODS = 3;
    localparam int SYM_CLKS = 170;
    localparam int CAP = 12; // 60000 * 200us

    logic clk = 0, rst = 1, start = 0, valid = 0, bitv = 0;
    logic ready, dim, busy;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    mfk_modulator #(.CLK_HZ(CLK_HZ), .F_PRE(F_PRE), .F_ZERO(F_ZERO), .F_ONE(F_ONE),
        .MAX_LOW_US(MAX_LOW_US), .PRE_PERIODS(PRE_PERIODS), .SYM_CLKS(SYM_CLKS)) dut (
        .clk_i(clk), .rst_i(rst), .start_i(start), .bit_valid_i(valid), .bit_i(bitv),
        .bit_ready_o(ready), .dim_o(dim), .busy_o(busy));

    // behavioural model
    bit q[$];
    int m_st = 0;    // 0 idle, 1 preamble, 2 data
    int m_per = 120; // clocks in current period
    int m_pos = 0, m_npre = 0, m_elap = 0, m_bitval = 0;

    function automatic int lowof(int per);
        return (per / 2 < CAP) ? per / 2 : CAP;
    endfunction

    function automatic bit m_ready();
        if (m_st == 0 || m_pos != m_per - 1) return 0;
        if (m_st == 1) return m_npre == PRE_PERIODS - 1;
        return m_elap + 1 >= SYM_CLKS;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pos = 0;
        end else if (m_st == 0) begin
            if (start) begin m_st = 1; m_per = CLK_HZ / F_PRE; m_pos = 0; m_npre = 0; end
        end else if (m_ready()) begin
            if (q.size() > 0) begin
                m_bitval = q[0];
                m_per = q[0] ? CLK_HZ / F_ONE : CLK_HZ / F_ZERO;
                void'(q.pop_front());
                m_st = 2; m_pos = 0; m_elap = 0;
            end else begin
                m_st = 0; m_pos = 0;
            end
        end else begin
            if (m_pos == m_per - 1) begin m_pos = 0; m_npre++; end
            else m_pos++;
            m_elap++;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    int low_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            logic exp_pin;
            string ptag;
            exp_pin = (m_st == 0) ? 1'b1 : (m_pos >= lowof(m_per));
            ptag = (m_st == 0) ? "R6 idle pin" : (m_st == 1) ? "R3 preamble pin" :
                   m_bitval ? "R2,R9 one tone pin" : "R1,R9 zero tone pin";
            chk(ptag, dim, exp_pin);
            chk("R5 ready", ready, m_ready());
            chk("R8 busy", busy, m_st != 0);
            if (!dim) low_run++;
            else begin
                if (low_run > 0) chk("R4 low phase within cap", low_run <= CAP, 1'b1);
                low_run = 0;
            end
        end
        valid = q.size() > 0;
        bitv  = (q.size() > 0) ? q[0] : 1'b0;
    end

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_st != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset pin", dim, 1'b1);
        chk("R6 reset busy", busy, 1'b0);
        chk("R6 reset ready", ready, 1'b0);
        rst = 0;
        // R1 R2 R3 R9: mixed payload
        q = '{1'b0, 1'b1, 1'b1, 1'b0};
        pulse_start();
        wait_idle();
        // R7: repeated start while busy is ignored
        q = '{1'b1, 1'b0};
        pulse_start();
        repeat (50) @(negedge clk);
        start = 1; repeat (5) @(negedge clk); start = 0;
        repeat (400) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        wait_idle();
        chk("R7 busy ended after ignored starts", busy, 1'b0);
        // R10: preamble only, no payload
        pulse_start();
        wait_idle();
        chk("R10 idle after empty frame", dim, 1'b1);
        // long run of ones and zeros
        q = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
        pulse_start();
        wait_idle();
        summary();
    end
endmodule